// File: doc/BRIEF.md
# Trap-on-Miss Address Translation Buffer

This block converts a 40-bit virtual address into a 36-bit physical address through a two-way set-associative buffer of 512 translations, arranged as 256 sets. Pages are 16 KB, so the low 14 address bits pass straight through. Bits 21:14 pick the set and bits 39:22 form the stored tag. Each stored translation holds a valid bit, a dirty bit, a reference bit, two access-rights bits, the tag and a 22-bit physical page number.

A lookup is answered in the same cycle. On a hit the block returns the physical address, the access-rights bits and the dirty bit. On a miss it raises a trap and leaves the page table alone: operating-system software walks the table itself and installs the translation through the fill port into a way it chooses. To help that choice, the block offers a victim way for the set that is currently addressed. The victim is based on the valid and reference bits, which give a rough least-recently-used order. A bulk command clears every reference bit at once, so software can age the entries from time to time.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit, `paddr[13:0]` equals `lk_vaddr[13:0]` and `paddr[35:14]` is the stored page number. The set is `lk_vaddr[21:14]` and the tag is `lk_vaddr[39:22]`.
- R2: A hit needs a valid entry in the addressed set whose tag equals the incoming tag. When both ways match, way 0 supplies the result.
- R3: When `lk_valid` is high and no way matches, `miss_trap` is high and `hit` is low in that cycle. A miss changes no stored state.
- R4: A hit sets the reference bit of the entry that hit, from the next cycle on.
- R5: A hit with `lk_store` high sets that entry's dirty bit from the next cycle on. A hit with `lk_store` low leaves the dirty bit unchanged.
- R6: `victim_way` for the addressed set is chosen in this order: the lowest-numbered invalid way; otherwise the lowest-numbered way whose reference bit is clear; otherwise way 0. The value 0 means way 0 and 1 means way 1.
- R7: `ref_clear` clears every reference bit. A hit in the same cycle still leaves its own entry's reference bit set.
- R8: A fill writes the valid bit, tag, page number, rights and dirty bit of the entry in `fill_way`, and clears its reference bit. The new contents are visible from the next cycle; a lookup in the fill cycle sees the old contents.
- R9: Synchronous active-high `rst` clears every valid, dirty and reference bit, so every lookup after reset misses and the victim is way 0.
- R10: While `lk_valid` is low, `hit` and `miss_trap` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_store | input | 1 | The lookup is for a write access |
| lk_vaddr | input | 40 | Virtual address to translate |
| hit | output | 1 | Translation found |
| miss_trap | output | 1 | No translation found; software refill required |
| paddr | output | 36 | Physical address (zero when no hit) |
| pg_dirty | output | 1 | Dirty bit of the hitting entry |
| pg_rights | output | 2 | Access-rights bits of the hitting entry |
| victim_way | output | 1 | Suggested way to replace in the addressed set |
| fill_en | input | 1 | Install a translation |
| fill_way | input | 1 | Way that receives the translation |
| fill_vpn | input | 26 | Virtual page number; bits 7:0 select the set, bits 25:8 are the tag |
| fill_ppn | input | 22 | Physical page number to store |
| fill_rights | input | 2 | Access-rights bits to store |
| fill_dirty | input | 1 | Initial dirty bit |
| ref_clear | input | 1 | Clear all reference bits |

## Verification
Some properties are checked on every cycle. A hit and a trap never occur together, and both stay low while no lookup is presented. A hit keeps the page offset unchanged. The first lookup after reset misses. A fill into way 0 is returned on a lookup of the same page in the next cycle. A store hit shows as dirty when the same address is looked up again next cycle. Other behaviour only shows over a planned sequence of lookups and fills, so the directed scenarios cover it. This covers the victim order as reference bits are set and cleared, the way-0 priority on duplicate tags, the interplay of a bulk clear with a same-cycle hit, and the old contents returned during a fill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned DEF_VA_W     = 40;
  localparam int unsigned DEF_PA_W     = 36;
  localparam int unsigned DEF_OFF_W    = 14;
  localparam int unsigned DEF_SET_W    = 8;
  localparam int unsigned DEF_RIGHTS_W = 2;
  localparam int unsigned NUM_WAYS     = 2;

  typedef enum logic [1:0] {
    VICT_INVALID = 2'd0,
    VICT_UNREF   = 2'd1,
    VICT_DEFAULT = 2'd2
  } vict_reason_e;
endpackage

// File: rtl/tlb_way_store.sv
module tlb_way_store #(
  parameter int unsigned SET_W    = 8,
  parameter int unsigned TAG_W    = 18,
  parameter int unsigned PPN_W    = 22,
  parameter int unsigned RIGHTS_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SET_W-1:0]    rd_set,
  output logic                rd_valid,
  output logic [TAG_W-1:0]    rd_tag,
  output logic [PPN_W-1:0]    rd_ppn,
  output logic [RIGHTS_W-1:0] rd_rights,
  output logic                rd_dirty,
  output logic                rd_ref,
  input  logic                touch_en,
  input  logic                mark_dirty,
  input  logic                ref_clear,
  input  logic                wr_en,
  input  logic [SET_W-1:0]    wr_set,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [PPN_W-1:0]    wr_ppn,
  input  logic [RIGHTS_W-1:0] wr_rights,
  input  logic                wr_dirty
);
  localparam int unsigned SETS = 1 << SET_W;

  logic [TAG_W-1:0]    tag_mem    [SETS];
  logic [PPN_W-1:0]    ppn_mem    [SETS];
  logic [RIGHTS_W-1:0] rights_mem [SETS];
  logic [SETS-1:0]     valid_q;
  logic [SETS-1:0]     dirty_q;
  logic [SETS-1:0]     ref_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_set]    <= wr_tag;
      ppn_mem[wr_set]    <= wr_ppn;
      rights_mem[wr_set] <= wr_rights;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      dirty_q <= '0;
      ref_q   <= '0;
    end else begin
      if (ref_clear)  ref_q <= '0;
      if (touch_en)   ref_q[rd_set] <= 1'b1;
      if (mark_dirty) dirty_q[rd_set] <= 1'b1;
      if (wr_en) begin
        valid_q[wr_set] <= 1'b1;
        dirty_q[wr_set] <= wr_dirty;
        ref_q[wr_set]   <= 1'b0;
      end
    end
  end

  assign rd_valid  = valid_q[rd_set];
  assign rd_dirty  = dirty_q[rd_set];
  assign rd_ref    = ref_q[rd_set];
  assign rd_tag    = tag_mem[rd_set];
  assign rd_ppn    = ppn_mem[rd_set];
  assign rd_rights = rights_mem[rd_set];
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick
  import tlb_pkg::*;
(
  input  logic [NUM_WAYS-1:0] way_valid,
  input  logic [NUM_WAYS-1:0] way_ref,
  output logic                victim,
  output vict_reason_e        reason
);
  always_comb begin
    victim = 1'b0;
    reason = VICT_DEFAULT;
    if (!way_valid[0]) begin
      victim = 1'b0;
      reason = VICT_INVALID;
    end else if (!way_valid[1]) begin
      victim = 1'b1;
      reason = VICT_INVALID;
    end else if (!way_ref[0]) begin
      victim = 1'b0;
      reason = VICT_UNREF;
    end else if (!way_ref[1]) begin
      victim = 1'b1;
      reason = VICT_UNREF;
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W     = DEF_VA_W,
  parameter int unsigned PA_W     = DEF_PA_W,
  parameter int unsigned OFF_W    = DEF_OFF_W,
  parameter int unsigned SET_W    = DEF_SET_W,
  parameter int unsigned RIGHTS_W = DEF_RIGHTS_W,
  localparam int unsigned VPN_W   = VA_W - OFF_W,
  localparam int unsigned TAG_W   = VPN_W - SET_W,
  localparam int unsigned PPN_W   = PA_W - OFF_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                lk_valid,
  input  logic                lk_store,
  input  logic [VA_W-1:0]     lk_vaddr,
  output logic                hit,
  output logic                miss_trap,
  output logic [PA_W-1:0]     paddr,
  output logic                pg_dirty,
  output logic [RIGHTS_W-1:0] pg_rights,
  output logic                victim_way,
  input  logic                fill_en,
  input  logic                fill_way,
  input  logic [VPN_W-1:0]    fill_vpn,
  input  logic [PPN_W-1:0]    fill_ppn,
  input  logic [RIGHTS_W-1:0] fill_rights,
  input  logic                fill_dirty,
  input  logic                ref_clear
);
  logic [OFF_W-1:0] lk_off;
  logic [SET_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;

  assign lk_off = lk_vaddr[OFF_W-1:0];
  assign lk_set = lk_vaddr[OFF_W+SET_W-1:OFF_W];
  assign lk_tag = lk_vaddr[VA_W-1:OFF_W+SET_W];

  logic [NUM_WAYS-1:0] w_valid;
  logic [NUM_WAYS-1:0] w_dirty;
  logic [NUM_WAYS-1:0] w_ref;
  logic [NUM_WAYS-1:0] w_match;
  logic [NUM_WAYS-1:0] w_sel;
  logic [TAG_W-1:0]    w_tag    [NUM_WAYS];
  logic [PPN_W-1:0]    w_ppn    [NUM_WAYS];
  logic [RIGHTS_W-1:0] w_rights [NUM_WAYS];

  // way 0 wins when both ways hold the tag
  assign w_sel[0] = w_match[0];
  assign w_sel[1] = w_match[1] & ~w_match[0];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic touch;
    assign touch      = lk_valid & w_sel[w];
    assign w_match[w] = w_valid[w] & (w_tag[w] == lk_tag);

    tlb_way_store #(
      .SET_W(SET_W), .TAG_W(TAG_W), .PPN_W(PPN_W), .RIGHTS_W(RIGHTS_W)
    ) u_store (
      .clk       (clk),
      .rst       (rst),
      .rd_set    (lk_set),
      .rd_valid  (w_valid[w]),
      .rd_tag    (w_tag[w]),
      .rd_ppn    (w_ppn[w]),
      .rd_rights (w_rights[w]),
      .rd_dirty  (w_dirty[w]),
      .rd_ref    (w_ref[w]),
      .touch_en  (touch),
      .mark_dirty(touch & lk_store),
      .ref_clear (ref_clear),
      .wr_en     (fill_en & (fill_way == 1'(w))),
      .wr_set    (fill_vpn[SET_W-1:0]),
      .wr_tag    (fill_vpn[VPN_W-1:SET_W]),
      .wr_ppn    (fill_ppn),
      .wr_rights (fill_rights),
      .wr_dirty  (fill_dirty)
    );
  end

  vict_reason_e vict_reason;
  tlb_victim_pick u_victim (
    .way_valid(w_valid),
    .way_ref  (w_ref),
    .victim   (victim_way),
    .reason   (vict_reason)
  );

  logic any_match;
  assign any_match = |w_match;

  always_comb begin
    hit       = lk_valid & any_match;
    miss_trap = lk_valid & ~any_match;
    paddr     = '0;
    pg_dirty  = 1'b0;
    pg_rights = '0;
    if (hit) begin
      if (w_sel[0]) begin
        paddr     = {w_ppn[0], lk_off};
        pg_dirty  = w_dirty[0];
        pg_rights = w_rights[0];
      end else begin
        paddr     = {w_ppn[1], lk_off};
        pg_dirty  = w_dirty[1];
        pg_rights = w_rights[1];
      end
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int unsigned VA_W  = 40,
  parameter int unsigned PA_W  = 36,
  parameter int unsigned OFF_W = 14,
  parameter int unsigned RIGHTS_W = 2,
  localparam int unsigned VPN_W = VA_W - OFF_W,
  localparam int unsigned PPN_W = PA_W - OFF_W
) (
  input logic                clk,
  input logic                rst,
  input logic                lk_valid,
  input logic                lk_store,
  input logic [VA_W-1:0]     lk_vaddr,
  input logic                hit,
  input logic                miss_trap,
  input logic [PA_W-1:0]     paddr,
  input logic                pg_dirty,
  input logic [RIGHTS_W-1:0] pg_rights,
  input logic                fill_en,
  input logic                fill_way,
  input logic [VPN_W-1:0]    fill_vpn,
  input logic [PPN_W-1:0]    fill_ppn,
  input logic [RIGHTS_W-1:0] fill_rights
);
  p_hit_trap_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(hit && miss_trap));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> (!hit && !miss_trap));

  p_offset_pass_r1: assert property (@(posedge clk) disable iff (rst)
    hit |-> (paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

  p_empty_after_reset_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !hit);

  p_fill_visible_r8: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !fill_way) |=>
      ((lk_valid && lk_vaddr[VA_W-1:OFF_W] == $past(fill_vpn)) |->
        (hit && paddr[PA_W-1:OFF_W] == $past(fill_ppn) &&
         pg_rights == $past(fill_rights))));

  p_store_dirty_r5: assert property (@(posedge clk) disable iff (rst)
    (hit && lk_store && !fill_en) |=>
      ((lk_valid && $stable(lk_vaddr) && hit) |-> pg_dirty));
endmodule

bind tlb_xlate tlb_xlate_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .RIGHTS_W(RIGHTS_W)
) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_store(lk_store),
  .lk_vaddr(lk_vaddr), .hit(hit), .miss_trap(miss_trap), .paddr(paddr),
  .pg_dirty(pg_dirty), .pg_rights(pg_rights), .fill_en(fill_en),
  .fill_way(fill_way), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
  .fill_rights(fill_rights)
);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid, lk_store;
  logic [39:0] lk_vaddr;
  logic        hit, miss_trap;
  logic [35:0] paddr;
  logic        pg_dirty;
  logic [1:0]  pg_rights;
  logic        victim_way;
  logic        fill_en, fill_way;
  logic [25:0] fill_vpn;
  logic [21:0] fill_ppn;
  logic [1:0]  fill_rights;
  logic        fill_dirty;
  logic        ref_clear;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tlb_xlate uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_store(lk_store),
    .lk_vaddr(lk_vaddr), .hit(hit), .miss_trap(miss_trap), .paddr(paddr),
    .pg_dirty(pg_dirty), .pg_rights(pg_rights), .victim_way(victim_way),
    .fill_en(fill_en), .fill_way(fill_way), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_rights(fill_rights), .fill_dirty(fill_dirty),
    .ref_clear(ref_clear)
  );

  function automatic logic [39:0] va(input logic [17:0] t, input logic [7:0] s,
                                     input logic [13:0] o);
    return {t, s, o};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    lk_valid = 0; lk_store = 0; fill_en = 0; ref_clear = 0;
  endtask

  // one cycle: fill (old contents visible to any lookup this cycle)
  task automatic fill(input logic w, input logic [17:0] t, input logic [7:0] s,
                      input logic [21:0] p, input logic [1:0] r, input logic d);
    @(negedge clk);
    lk_valid = 0; lk_store = 0; ref_clear = 0;
    fill_en = 1; fill_way = w; fill_vpn = {t, s};
    fill_ppn = p; fill_rights = r; fill_dirty = d;
  endtask

  // one cycle: lookup, outputs sampled 1 ns after driving
  task automatic look(input logic [39:0] a, input logic st, input logic clr);
    @(negedge clk);
    fill_en = 0; ref_clear = clr;
    lk_valid = 1; lk_store = st; lk_vaddr = a;
    #1;
  endtask

  task automatic peek_victim(input logic [7:0] s, input logic exp, input string req);
    @(negedge clk);
    fill_en = 0; ref_clear = 0; lk_valid = 0; lk_store = 0;
    lk_vaddr = va(18'h0, s, 14'h0);
    #1;
    chk(victim_way == exp, req, victim_way, exp);
  endtask

  task automatic t_reset();
    look(va(18'h3, 8'h5, 14'h10), 0, 0);
    chk(miss_trap && !hit, "R9 R3 miss after reset", {hit, miss_trap}, 2'b01);
    peek_victim(8'h5, 0, "R9 victim after reset");
    chk(!hit && !miss_trap, "R10 idle outputs", {hit, miss_trap}, 2'b00);
  endtask

  task automatic t_fill_hit();
    fill(0, 18'h2ABCD, 8'h05, 22'h1F00A, 2'b10, 0);
    look(va(18'h2ABCD, 8'h05, 14'h1234), 0, 0);
    chk(hit && !miss_trap, "R8 fill then hit", hit, 1);
    chk(paddr == {22'h1F00A, 14'h1234}, "R1 physical address", paddr,
        {22'h1F00A, 14'h1234});
    chk(pg_rights == 2'b10, "R8 rights", pg_rights, 2'b10);
    chk(pg_dirty == 0, "R8 dirty from fill", pg_dirty, 0);
    look(va(18'h2ABCC, 8'h05, 14'h1234), 0, 0);
    chk(miss_trap && !hit, "R2 tag mismatch misses", miss_trap, 1);
    look(va(18'h2ABCD, 8'h06, 14'h1234), 0, 0);
    chk(miss_trap && !hit, "R2 other set misses", miss_trap, 1);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    fill_en = 1; fill_way = 1; fill_vpn = {18'h00777, 8'h05};
    fill_ppn = 22'h00ABC; fill_rights = 2'b01; fill_dirty = 1;
    lk_valid = 1; lk_store = 0; ref_clear = 0;
    lk_vaddr = va(18'h00777, 8'h05, 14'h0);
    #1;
    chk(miss_trap, "R8 same-cycle lookup sees old", miss_trap, 1);
    look(va(18'h00777, 8'h05, 14'h3FFF), 0, 0);
    chk(hit && paddr == {22'h00ABC, 14'h3FFF} && pg_dirty,
        "R8 way1 visible next cycle", paddr, {22'h00ABC, 14'h3FFF});
  endtask

  task automatic t_priority();
    fill(1, 18'h2ABCD, 8'h05, 22'h3FFFF, 2'b11, 1);
    look(va(18'h2ABCD, 8'h05, 14'h0001), 0, 0);
    chk(hit && paddr[35:14] == 22'h1F00A, "R2 way0 priority", paddr[35:14],
        22'h1F00A);
  endtask

  task automatic t_dirty();
    fill(0, 18'h00111, 8'h09, 22'h00222, 2'b00, 0);
    look(va(18'h00111, 8'h09, 14'h5), 0, 0);
    look(va(18'h00111, 8'h09, 14'h5), 0, 0);
    chk(hit && !pg_dirty, "R5 load leaves dirty clear", pg_dirty, 0);
    look(va(18'h00111, 8'h09, 14'h5), 1, 0);
    chk(!pg_dirty, "R5 store hit shows old dirty", pg_dirty, 0);
    look(va(18'h00111, 8'h09, 14'h5), 0, 0);
    chk(hit && pg_dirty, "R5 dirty after store", pg_dirty, 1);
    look(va(18'h00112, 8'h09, 14'h5), 1, 0);
    chk(miss_trap, "R3 store miss traps", miss_trap, 1);
    peek_victim(8'h09, 1, "R3 miss leaves way1 invalid");
  endtask

  task automatic t_victim();
    peek_victim(8'h14, 0, "R6 both invalid");
    fill(0, 18'h00AAA, 8'h14, 22'h1, 2'b00, 0);
    peek_victim(8'h14, 1, "R6 invalid way1 first");
    fill(1, 18'h00BBB, 8'h14, 22'h2, 2'b00, 0);
    peek_victim(8'h14, 0, "R6 both unreferenced");
    look(va(18'h00AAA, 8'h14, 14'h0), 0, 0);
    peek_victim(8'h14, 1, "R4 hit sets way0 ref");
    look(va(18'h00BBB, 8'h14, 14'h0), 0, 0);
    peek_victim(8'h14, 0, "R6 both referenced");
    @(negedge clk);
    lk_valid = 0; fill_en = 0; ref_clear = 1;
    look(va(18'h00AAA, 8'h14, 14'h0), 0, 0);
    peek_victim(8'h14, 1, "R7 clear dropped way1 ref");
    look(va(18'h00BBB, 8'h14, 14'h0), 0, 0);
    peek_victim(8'h14, 0, "R4 both referenced again");
    look(va(18'h00AAA, 8'h14, 14'h0), 0, 1);
    peek_victim(8'h14, 1, "R7 same-cycle hit keeps ref");
    fill(0, 18'h00CCC, 8'h14, 22'h3, 2'b00, 0);
    peek_victim(8'h14, 0, "R8 fill clears ref");
  endtask

  initial begin
    rst = 1; lk_valid = 0; lk_store = 0; lk_vaddr = '0; fill_en = 0;
    fill_way = 0; fill_vpn = '0; fill_ppn = '0; fill_rights = '0;
    fill_dirty = 0; ref_clear = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_fill_hit();
    t_same_cycle();
    t_priority();
    t_dirty();
    t_victim();
    fill(0, 18'h00777, 8'h05, 22'h5, 2'b00, 0);
    @(negedge clk); fill_en = 0; rst = 1;
    @(negedge clk); rst = 0;
    look(va(18'h00777, 8'h05, 14'h0), 0, 0);
    chk(miss_trap && !hit, "R9 reset empties buffer", miss_trap, 1);
    idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule